// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block decides, every cycle, whether the front of a five-stage in-order pipeline advances, holds or is cleared. It watches the instruction in the memory stage and the two source operands of the instruction in the execute stage. When a load in the memory stage produces a register that the execute-stage instruction reads, the block freezes the program counter and the two front pipeline registers and turns the slot entering the memory stage into a bubble. The loaded value can then be forwarded one cycle later.

When the execute stage resolves a taken branch or jump, the block clears the fetch/decode and decode/execute registers, so the two younger instructions already fetched are discarded. It also steers the next-PC multiplexer to the target that the execute-stage ALU computed. When no hazard applies, every enable and clear follows the original control lines supplied from outside, so single-stepping and reset clears keep working.

The block has no internal state: a priority selector picks one of three modes (run, stall, flush) from the current inputs, and each output is decoded from that mode. Transitions are purely combinational: RUN→STALL when a load-use match appears, any→FLUSH when the taken flag is high, and back to RUN when neither holds.

Top module: `hzc_stall_flush_ctrl`

## Requirements
- R1: A load-use hazard exists when `mem_wr_en` is 1, `mem_is_load` is 1, `mem_rd` is nonzero and equals `ex_rs1` or `ex_rs2`. With a load-use hazard and `ex_taken` at 0, `pc_en`, `fd_en` and `dx_en` are all 0.
- R2: Under the same conditions as R1, `xm_clr` is 1, while `fd_clr` and `dx_clr` follow `orig_clr`.
- R3: With no load-use hazard and `ex_taken` at 0, `pc_en` equals `orig_pc_en`, `xm_clr`, `fd_clr` and `dx_clr` equal `orig_clr`, and `fd_en` and `dx_en` are 1.
- R4: When `ex_taken` is 1, `fd_clr` and `dx_clr` are 1. When `ex_taken` is 0 and there is no hazard, they equal `orig_clr`.
- R5: `pc_next` equals `ex_alu_result` when `ex_taken` is 1, and `pc_seq` otherwise.
- R6: A memory-stage destination of register 0 never causes a stall, even when a source is also 0.
- R7: A memory-stage instruction that is not a load, or that is a load with `mem_wr_en` at 0, never causes a stall, even when the register numbers match.
- R8: When a load-use hazard and `ex_taken` at 1 coincide, the flush wins. `pc_en` equals `orig_pc_en`, `fd_en` and `dx_en` are 1, `xm_clr` equals `orig_clr`, and `fd_clr` and `dx_clr` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | 5 | First source register number of the execute-stage instruction |
| ex_rs2 | input | 5 | Second source register number of the execute-stage instruction |
| mem_rd | input | 5 | Destination register number of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes the register file |
| mem_is_load | input | 1 | Memory-stage instruction reads data memory |
| ex_taken | input | 1 | Execute stage resolved a taken branch or jump |
| orig_pc_en | input | 1 | Original PC enable from outside |
| orig_clr | input | 1 | Original pipeline-register clear from outside |
| pc_seq | input | 64 | Sequential next PC |
| ex_alu_result | input | 64 | Branch or jump target computed in execute |
| pc_en | output | 1 | PC register enable |
| fd_en | output | 1 | Fetch/decode register enable |
| dx_en | output | 1 | Decode/execute register enable |
| fd_clr | output | 1 | Fetch/decode register clear |
| dx_clr | output | 1 | Decode/execute register clear |
| xm_clr | output | 1 | Execute/memory register clear |
| pc_next | output | 64 | Value loaded into the PC |

## Verification
The load-use stall and the taken-branch flush can both be requested in the same cycle. This happens when the execute-stage instruction resolves as taken while reading a register that the load ahead of it is about to write. The bench provokes this by raising `ex_taken` together with a matching load in the memory stage, once with `orig_clr` low and once with it high. It judges the result against R8: the front registers keep advancing, the two younger stages are cleared, and no bubble is forced into the memory stage.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_STALL = 2'd1,
        MODE_FLUSH = 2'd2
    } hzc_mode_e;
endpackage

// File: rtl/hzc_load_use_detect.sv
module hzc_load_use_detect #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0][REG_AW-1:0] src_idx,
    input  logic [REG_AW-1:0]              dst_idx,
    input  logic                           dst_we,
    input  logic                           dst_is_load,
    output logic                           hit
);
    logic [NUM_SRC-1:0] src_match;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
            assign src_match[i] = (src_idx[i] == dst_idx);
        end
    endgenerate

    // register 0 is hard-wired, a write to it never produces a value
    assign hit = dst_we && dst_is_load && (dst_idx != '0) && (|src_match);
endmodule

// File: rtl/hzc_mode_ctrl.sv
module hzc_mode_ctrl
    import hzc_pkg::*;
(
    input  logic      stall_hit,
    input  logic      redirect,
    input  logic      orig_pc_en,
    input  logic      orig_clr,
    output hzc_mode_e mode,
    output logic      pc_en,
    output logic      fd_en,
    output logic      dx_en,
    output logic      fd_clr,
    output logic      dx_clr,
    output logic      xm_clr
);
    // mode selection: flush outranks stall, younger work is dropped anyway
    always_comb begin
        if (redirect)       mode = MODE_FLUSH;
        else if (stall_hit) mode = MODE_STALL;
        else                mode = MODE_RUN;
    end

    // output decode per mode
    always_comb begin
        pc_en  = orig_pc_en;
        fd_en  = 1'b1;
        dx_en  = 1'b1;
        fd_clr = orig_clr;
        dx_clr = orig_clr;
        xm_clr = orig_clr;
        unique case (mode)
            MODE_RUN: begin
            end
            MODE_STALL: begin
                pc_en  = 1'b0;
                fd_en  = 1'b0;
                dx_en  = 1'b0;
                xm_clr = 1'b1;
            end
            MODE_FLUSH: begin
                fd_clr = 1'b1;
                dx_clr = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/hzc_pc_select.sv
module hzc_pc_select #(
    parameter int XLEN = 64
) (
    input  logic            take_target,
    input  logic [XLEN-1:0] seq_pc,
    input  logic [XLEN-1:0] target_pc,
    output logic [XLEN-1:0] next_pc
);
    assign next_pc = take_target ? target_pc : seq_pc;
endmodule

// File: rtl/hzc_stall_flush_ctrl.sv
module hzc_stall_flush_ctrl
    import hzc_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int XLEN   = 64
) (
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wr_en,
    input  logic              mem_is_load,
    input  logic              ex_taken,
    input  logic              orig_pc_en,
    input  logic              orig_clr,
    input  logic [XLEN-1:0]   pc_seq,
    input  logic [XLEN-1:0]   ex_alu_result,
    output logic              pc_en,
    output logic              fd_en,
    output logic              dx_en,
    output logic              fd_clr,
    output logic              dx_clr,
    output logic              xm_clr,
    output logic [XLEN-1:0]   pc_next
);
    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0][REG_AW-1:0] src_vec;
    logic                           lu_hit;
    hzc_mode_e                      mode;

    assign src_vec[0] = ex_rs1;
    assign src_vec[1] = ex_rs2;

    hzc_load_use_detect #(
        .REG_AW  (REG_AW),
        .NUM_SRC (NUM_SRC)
    ) u_detect (
        .src_idx     (src_vec),
        .dst_idx     (mem_rd),
        .dst_we      (mem_wr_en),
        .dst_is_load (mem_is_load),
        .hit         (lu_hit)
    );

    hzc_mode_ctrl u_ctrl (
        .stall_hit  (lu_hit),
        .redirect   (ex_taken),
        .orig_pc_en (orig_pc_en),
        .orig_clr   (orig_clr),
        .mode       (mode),
        .pc_en      (pc_en),
        .fd_en      (fd_en),
        .dx_en      (dx_en),
        .fd_clr     (fd_clr),
        .dx_clr     (dx_clr),
        .xm_clr     (xm_clr)
    );

    hzc_pc_select #(
        .XLEN (XLEN)
    ) u_pcsel (
        .take_target (ex_taken),
        .seq_pc      (pc_seq),
        .target_pc   (ex_alu_result),
        .next_pc     (pc_next)
    );

    // checks relating the detector, the mode decoder and the PC mux
    always_comb begin
        if (lu_hit && !ex_taken) begin
            assert_stall_freeze_R1: assert (!pc_en && !fd_en && !dx_en);
            assert_stall_bubble_R2: assert (xm_clr);
        end
        if (!lu_hit && !ex_taken) begin
            assert_run_follow_R3: assert (fd_en && dx_en && (pc_en == orig_pc_en) && (xm_clr == orig_clr));
        end
        if (ex_taken) begin
            assert_flush_front_R4: assert (fd_clr && dx_clr);
            assert_target_pick_R5: assert (pc_next == ex_alu_result);
        end
        if (mem_rd == '0) begin
            assert_zero_reg_R6: assert (fd_en && dx_en);
        end
        if (!(mem_wr_en && mem_is_load)) begin
            assert_non_load_R7: assert (fd_en && dx_en);
        end
        if (lu_hit && ex_taken) begin
            assert_flush_wins_R8: assert (fd_en && dx_en && (mode == MODE_FLUSH));
        end
    end
endmodule

// File: tb/hzc_stall_flush_ctrl_tb.sv
module hzc_stall_flush_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [4:0]      ex_rs1, ex_rs2, mem_rd;
    logic            mem_wr_en, mem_is_load, ex_taken, orig_pc_en, orig_clr;
    logic [XLEN-1:0] pc_seq, ex_alu_result;
    logic            pc_en, fd_en, dx_en, fd_clr, dx_clr, xm_clr;
    logic [XLEN-1:0] pc_next;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    hzc_stall_flush_ctrl dut_i (
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .mem_rd(mem_rd),
        .mem_wr_en(mem_wr_en), .mem_is_load(mem_is_load), .ex_taken(ex_taken),
        .orig_pc_en(orig_pc_en), .orig_clr(orig_clr),
        .pc_seq(pc_seq), .ex_alu_result(ex_alu_result),
        .pc_en(pc_en), .fd_en(fd_en), .dx_en(dx_en),
        .fd_clr(fd_clr), .dx_clr(dx_clr), .xm_clr(xm_clr), .pc_next(pc_next)
    );

    task automatic chk(input string req, input string what, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] rs1, input logic [4:0] rs2, input logic [4:0] rd,
                         input logic wr, input logic ld, input logic tk,
                         input logic open, input logic oclr);
        @(negedge clk);
        ex_rs1 = rs1; ex_rs2 = rs2; mem_rd = rd;
        mem_wr_en = wr; mem_is_load = ld; ex_taken = tk;
        orig_pc_en = open; orig_clr = oclr;
        pc_seq = 64'h1000; ex_alu_result = 64'h2468;
        #1;
    endtask

    task automatic expect_run(input string req, input logic open, input logic oclr);
        chk(req, "pc_en", pc_en, open);
        chk(req, "fd_en", fd_en, 1'b1);
        chk(req, "dx_en", dx_en, 1'b1);
        chk(req, "xm_clr", xm_clr, oclr);
        chk(req, "fd_clr", fd_clr, oclr);
        chk(req, "dx_clr", dx_clr, oclr);
    endtask

    task automatic t_idle;
        drive(5'd1, 5'd2, 5'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_run("R3", 1'b1, 1'b0);
        chk("R5", "pc_next", pc_next, 64'h1000);
    endtask

    task automatic t_stall_src(input bit second);
        drive(second ? 5'd9 : 5'd5, second ? 5'd5 : 5'd7, 5'd5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R1", "pc_en", pc_en, 1'b0);
        chk("R1", "fd_en", fd_en, 1'b0);
        chk("R1", "dx_en", dx_en, 1'b0);
        chk("R2", "xm_clr", xm_clr, 1'b1);
        chk("R2", "fd_clr", fd_clr, 1'b0);
        chk("R2", "dx_clr", dx_clr, 1'b0);
    endtask

    task automatic t_stall_orig_clr;
        drive(5'd12, 5'd12, 5'd12, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        chk("R2", "fd_clr follows orig", fd_clr, 1'b1);
        chk("R1", "pc_en", pc_en, 1'b0);
    endtask

    task automatic t_not_load;
        drive(5'd5, 5'd6, 5'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_run("R7", 1'b1, 1'b0);
        drive(5'd5, 5'd6, 5'd6, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        expect_run("R7", 1'b1, 1'b0);
    endtask

    task automatic t_zero_reg;
        drive(5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        expect_run("R6", 1'b1, 1'b0);
    endtask

    task automatic t_passthrough;
        drive(5'd1, 5'd2, 5'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        expect_run("R3", 1'b0, 1'b1);
        drive(5'd1, 5'd2, 5'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        expect_run("R4", 1'b1, 1'b0);
    endtask

    task automatic t_redirect;
        drive(5'd1, 5'd2, 5'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R4", "fd_clr", fd_clr, 1'b1);
        chk("R4", "dx_clr", dx_clr, 1'b1);
        chk("R4", "xm_clr", xm_clr, 1'b0);
        chk("R5", "pc_next", pc_next, 64'h2468);
    endtask

    task automatic t_both(input logic oclr);
        drive(5'd8, 5'd4, 5'd8, 1'b1, 1'b1, 1'b1, 1'b1, oclr);
        chk("R8", "pc_en", pc_en, 1'b1);
        chk("R8", "fd_en", fd_en, 1'b1);
        chk("R8", "dx_en", dx_en, 1'b1);
        chk("R8", "xm_clr", xm_clr, oclr);
        chk("R8", "fd_clr", fd_clr, 1'b1);
        chk("R8", "dx_clr", dx_clr, 1'b1);
        chk("R5", "pc_next", pc_next, 64'h2468);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_idle();
        t_stall_src(1'b0);
        t_stall_src(1'b1);
        t_stall_orig_clr();
        t_not_load();
        t_zero_reg();
        t_passthrough();
        t_redirect();
        t_both(1'b0);
        t_both(1'b1);
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (10000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule